// File: doc/BRIEF.md
# External Interrupt Controller

This block watches 32 external interrupt pins. Each pin is synchronised to the core clock and checked against a trigger type chosen for that pin: high level, low level, rising edge, falling edge or both edges. A detected event sets the pin's pending bit. A per-pin mask decides whether that pending bit reaches an interrupt line. Pins 0 to 15 each drive their own registered output towards a vectored interrupt controller. Pins 16 to 31 share one registered output, which is the OR of their unmasked pending bits.

Software uses a 32-bit register bus with a read strobe, a write strobe and a 4-bit word address. The address space holds four kinds of register, each with four banks of eight pins. Trigger words have word indices 0 to 3. Mask banks have indices 4 to 7. Pending banks have indices 8 to 11 and are cleared by writing ones. Masked status banks have indices 12 to 15 and are read-only. A handler for the shared line reads the status banks to find which pins fired, and services the highest set bit first.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every trigger field reads 0 (low level), and every interrupt output is low.
- R2: Trigger word b (index b, 0..3) covers pins 8b..8b+7. Pin 8b+k uses bits [4k+2:4k] of that word. Bit 4k+3 is ignored when written and reads 0.
- R3: Code 3'b000 (low level) sets the pending bit on every clock while the synchronised pin is 0. Code 3'b001 (high level) does the same while the pin is 1.
- R4: Code 3'b010 sets pending on a 1-to-0 change of the synchronised pin. Code 3'b011 sets it on a 0-to-1 change. Any code with bit 2 set (3'b1xx) sets it on either change.
- R5: Mask bank b (index 4+b) holds mask bits for pins 8b..8b+7 in data bits [7:0]. A mask bit of 1 keeps the pin's pending bit off its output but does not stop the pending bit from latching. A mask bit of 0 lets it through.
- R6: Pending bank b (index 8+b) reads the raw pending bits of pins 8b..8b+7 in bits [7:0]. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R7: For a level trigger, a cleared pending bit sets again while the level is still present. The clear only lasts once the level has gone away.
- R8: When an event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Output irq_direct[i], for i in 0..15, is high exactly when pin i is pending and unmasked, one register stage after the pending state.
- R10: Output irq_group is high exactly when at least one of pins 16..31 is pending and unmasked, one register stage after the pending state.
- R11: Status bank b (index 12+b) reads pending AND NOT mask for pins 8b..8b+7 in bits [7:0]. Read data appears on bus_rdata in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pins | input | 32 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word index: bits [3:2] select the register kind, bits [1:0] select the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_direct | output | 16 | Per-pin interrupt lines for pins 0..15 |
| irq_group | output | 1 | Shared interrupt line for pins 16..31 |

## Verification
The hardest case to reach from the ports is a clear that arrives in the same cycle as a new event on the same bit. A pin edge only reaches the pending logic after two synchroniser flops, so landing it exactly on a bus write is timing-sensitive. The stimulus gets there with level triggers instead. An active level raises a set request on every clock, so every pending-bit clear written while the level is held is a collision. The bench checks that such a bit still reads 1, and that it reads 0 once the level is gone and the bit is cleared again. Randomised rounds then mix all trigger codes, masks and pin changes, with a full clear before each pin change.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // register kind, taken from bus_addr[3:2]
  typedef enum logic [1:0] {
    RK_TRIG   = 2'd0,
    RK_MASK   = 2'd1,
    RK_PEND   = 2'd2,
    RK_STATUS = 2'd3
  } reg_kind_e;

  // trigger codes; any code with bit 2 set means both edges
  localparam logic [2:0] TRG_LOW  = 3'b000;
  localparam logic [2:0] TRG_HIGH = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_RISE = 3'b011;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int TRIG_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        level_in,
  input  logic [NUM_PINS*TRIG_W-1:0] trig_flat,
  output logic [NUM_PINS-1:0]        set_vec
);
  logic [NUM_PINS-1:0] prev_q;

  // previous sampled level, used for edge comparison
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_in;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [TRIG_W-1:0] code;
    logic              cur, old;
    assign code = trig_flat[p*TRIG_W +: TRIG_W];
    assign cur  = level_in[p];
    assign old  = prev_q[p];

    always_comb begin
      if (code[2]) begin
        set_vec[p] = cur ^ old;
      end else begin
        case (code)
          TRG_LOW:  set_vec[p] = ~cur;
          TRG_HIGH: set_vec[p] = cur;
          TRG_FALL: set_vec[p] = old & ~cur;
          TRG_RISE: set_vec[p] = cur & ~old;
          default:  set_vec[p] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_PINS      = 32,
  parameter int PINS_PER_BANK = 8,
  parameter int SLOT_W        = 4,
  parameter int TRIG_W        = 3,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        set_vec,
  output logic [NUM_PINS*TRIG_W-1:0] trig_flat,
  output logic [NUM_PINS-1:0]        mask_vec,
  output logic [NUM_PINS-1:0]        pend_vec,
  output logic [NUM_PINS-1:0]        clr_vec
);
  localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  logic [TRIG_W-1:0]       trig_q [NUM_PINS];
  logic [NUM_PINS-1:0]     mask_q, pend_q;
  reg_kind_e               kind;
  logic [BANK_W-1:0]       bank;
  logic [DATA_W-1:0]       trig_word;
  logic                    unused_bits;

  assign kind = reg_kind_e'(bus_addr[ADDR_W-1 -: 2]);
  assign bank = bus_addr[BANK_W-1:0];
  assign unused_bits = ^{bus_wdata, bus_addr};

  // write-one-to-clear request for the pending banks
  always_comb begin
    clr_vec = '0;
    if (bus_wr && kind == RK_PEND)
      clr_vec[bank*PINS_PER_BANK +: PINS_PER_BANK] = bus_wdata[PINS_PER_BANK-1:0];
  end

  // trigger fields and masks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) trig_q[p] <= TRG_LOW;
      mask_q <= '1;
    end else if (bus_wr) begin
      if (kind == RK_TRIG) begin
        for (int k = 0; k < PINS_PER_BANK; k++)
          trig_q[bank*PINS_PER_BANK + k] <= bus_wdata[k*SLOT_W +: TRIG_W];
      end
      if (kind == RK_MASK)
        mask_q[bank*PINS_PER_BANK +: PINS_PER_BANK] <= bus_wdata[PINS_PER_BANK-1:0];
    end
  end

  // pending: a new event outranks a clear of the same bit
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  // trigger word view for read-back; pad bits read 0
  always_comb begin
    trig_word = '0;
    for (int k = 0; k < PINS_PER_BANK; k++)
      trig_word[k*SLOT_W +: TRIG_W] = trig_q[bank*PINS_PER_BANK + k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (kind)
        RK_TRIG:   bus_rdata <= trig_word;
        RK_MASK:   bus_rdata[PINS_PER_BANK-1:0] <= mask_q[bank*PINS_PER_BANK +: PINS_PER_BANK];
        RK_PEND:   bus_rdata[PINS_PER_BANK-1:0] <= pend_q[bank*PINS_PER_BANK +: PINS_PER_BANK];
        RK_STATUS: bus_rdata[PINS_PER_BANK-1:0] <= pend_q[bank*PINS_PER_BANK +: PINS_PER_BANK]
                                                 & ~mask_q[bank*PINS_PER_BANK +: PINS_PER_BANK];
        default:   bus_rdata <= '0;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
    assign trig_flat[p*TRIG_W +: TRIG_W] = trig_q[p];
  end

  assign mask_vec = mask_q;
  assign pend_vec = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_PINS      = 32,
  parameter int NUM_DIRECT    = 16,
  parameter int PINS_PER_BANK = 8,
  parameter int SLOT_W        = 4,
  parameter int TRIG_W        = 3,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pins,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_group
);
  localparam int NUM_SHARED = NUM_PINS - NUM_DIRECT;

  logic [NUM_PINS-1:0]        pins_sync;
  logic [NUM_PINS-1:0]        set_vec, clr_vec, mask_vec, pend_vec, live_vec;
  logic [NUM_PINS*TRIG_W-1:0] trig_flat;

  eic_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pins), .sync_out(pins_sync)
  );

  eic_detect #(.NUM_PINS(NUM_PINS), .TRIG_W(TRIG_W)) u_detect (
    .clk(clk), .rst(rst), .level_in(pins_sync), .trig_flat(trig_flat),
    .set_vec(set_vec)
  );

  eic_regs #(
    .NUM_PINS(NUM_PINS), .PINS_PER_BANK(PINS_PER_BANK), .SLOT_W(SLOT_W),
    .TRIG_W(TRIG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_vec(set_vec), .trig_flat(trig_flat), .mask_vec(mask_vec),
    .pend_vec(pend_vec), .clr_vec(clr_vec)
  );

  assign live_vec = pend_vec & ~mask_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_direct <= '0;
      irq_group  <= 1'b0;
    end else begin
      irq_direct <= live_vec[NUM_DIRECT-1:0];
      irq_group  <= |live_vec[NUM_PINS-1 -: NUM_SHARED];
    end
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_PINS   = 32,
  parameter int NUM_DIRECT = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_DIRECT-1:0] irq_direct,
  input logic                  irq_group,
  input logic [NUM_PINS-1:0]   mask_vec,
  input logic [NUM_PINS-1:0]   pend_vec,
  input logic [NUM_PINS-1:0]   set_vec,
  input logic [NUM_PINS-1:0]   clr_vec
);
  localparam logic [DATA_W-1:0] PAD_BITS = {(DATA_W/4){4'b1000}};

  p_reset_masked_r1: assert property (@(posedge clk)
    rst |=> (mask_vec == '1 && pend_vec == '0 && irq_direct == '0 && !irq_group));

  p_slot_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[ADDR_W-1 -: 2] == 2'd0) |=> ((bus_rdata & PAD_BITS) == '0));

  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_vec & $past(clr_vec & ~set_vec)) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend_vec ^ $past(pend_vec)) & $past(~clr_vec & ~set_vec)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_vec & $past(set_vec)) == $past(set_vec)));

  p_direct_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_direct == $past(pend_vec[NUM_DIRECT-1:0] & ~mask_vec[NUM_DIRECT-1:0])));

  p_group_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_group == $past(|(pend_vec[NUM_PINS-1:NUM_DIRECT] & ~mask_vec[NUM_PINS-1:NUM_DIRECT]))));
endmodule

bind ext_irq_ctrl eic_checker #(
  .NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_eic_checker (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_direct(irq_direct), .irq_group(irq_group),
  .mask_vec(mask_vec), .pend_vec(pend_vec), .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_direct;
  logic        irq_group;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .pins(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_direct(irq_direct), .irq_group(irq_group)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic bit lvl_act(logic [2:0] c, logic v);
    return (c == 3'b000 && !v) || (c == 3'b001 && v);
  endfunction

  function automatic bit edge_hit(logic [2:0] c, logic o, logic n);
    if (c[2]) return o != n;
    if (c == 3'b010) return o && !n;
    if (c == 3'b011) return !o && n;
    return 1'b0;
  endfunction

  task automatic clear_all();
    for (int b = 0; b < 4; b++) bus_write(4'(8 + b), 32'hFF);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
  end

  initial begin
    logic [31:0] rd, exp_pend, mask;
    logic [2:0]  cfg [32];
    logic [31:0] old_pins, new_pins;
    void'($urandom(32'd20240611));

    wait_cyc(3);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    for (int b = 0; b < 4; b++) begin
      bus_read(4'(4 + b), rd); check("R1 mask", rd, 32'hFF);
      bus_read(4'(b), rd);     check("R1 trig", rd, 32'h0);
    end
    check("R1 irq_direct", {16'h0, irq_direct}, 32'h0);
    check("R1 irq_group", {31'h0, irq_group}, 32'h0);

    // R2: pad bits ignored, fields placed per slot
    bus_write(4'd2, 32'hFFFF_FFFF);
    bus_read(4'd2, rd); check("R2 pad", rd, 32'h7777_7777);
    bus_write(4'd2, 32'h0000_0000);

    // R7 and R8: held level re-sets a cleared bit (set wins the collision)
    bus_write(4'd0, 32'h0000_0001);          // pin 0 high level
    pins[0] = 1'b1; wait_cyc(5);
    bus_write(4'd8, 32'h01);
    bus_read(4'd8, rd); check("R8 set beats clear", rd & 32'h1, 32'h1);
    pins[0] = 1'b0; wait_cyc(5);
    bus_read(4'd8, rd); check("R7 still set after level gone", rd & 32'h1, 32'h1);
    bus_write(4'd8, 32'h01);
    bus_read(4'd8, rd); check("R7 clear holds once level gone", rd & 32'h1, 32'h0);

    // R6: clearing one bit leaves others
    bus_write(4'd0, 32'h0000_3333);          // pins 0..3 rising
    clear_all();
    pins[3:0] = 4'hF; wait_cyc(6);
    bus_write(4'd8, 32'h04);
    bus_read(4'd8, rd); check("R6 single clear", rd & 32'hF, 32'hB);
    pins[3:0] = 4'h0;

    // R5, R9: unmask pin 1 only
    bus_write(4'd4, 32'hFD); wait_cyc(3);
    check("R9 direct line", {16'h0, irq_direct}, 32'h2);
    check("R5 masked pins quiet", {16'h0, irq_direct} & 32'hD, 32'h0);
    bus_write(4'd4, 32'hFF);

    // randomised rounds, R3 R4 R5 R6 R9 R10 R11
    old_pins = pins;
    for (int it = 0; it < 60; it++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] w;
        w = $urandom();
        for (int k = 0; k < 8; k++) cfg[b*8 + k] = w[k*4 +: 3];
        bus_write(4'(b), w);
      end
      mask = $urandom();
      mask[31:16] = (it % 4 == 0) ? 16'hFFFF : mask[31:16];
      for (int b = 0; b < 4; b++) bus_write(4'(4 + b), {24'h0, mask[b*8 +: 8]});
      wait_cyc(4);
      clear_all();
      wait_cyc(2);
      new_pins = (it % 5 == 0) ? ~old_pins : $urandom();
      pins = new_pins;
      wait_cyc(8);
      for (int p = 0; p < 32; p++)
        exp_pend[p] = lvl_act(cfg[p], old_pins[p]) | lvl_act(cfg[p], new_pins[p])
                    | edge_hit(cfg[p], old_pins[p], new_pins[p]);
      for (int b = 0; b < 4; b++) begin
        bus_read(4'(8 + b), rd);
        check("R3 R4 R6 pending", rd, {24'h0, exp_pend[b*8 +: 8]});
        bus_read(4'(12 + b), rd);
        check("R11 status", rd, {24'h0, exp_pend[b*8 +: 8] & ~mask[b*8 +: 8]});
      end
      check("R9 direct", {16'h0, irq_direct}, {16'h0, exp_pend[15:0] & ~mask[15:0]});
      check("R10 group", {31'h0, irq_group}, {31'h0, |(exp_pend[31:16] & ~mask[31:16])});
      old_pins = new_pins;
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule